// File: doc/BRIEF.md
# Serial Companion-Register Access Bridge

This block sits on a processor's memory-mapped bus and gives software read and write access to the 16-bit registers of a companion power-management device. That device is reached over a four-wire serial link. A bus write that lands in a 4 KB slave window is placed in an 8-entry write queue. The queue is then sent out, one serial frame per entry, in the order the writes arrived. To read, software writes the device register address to a read-command register; that write alone starts the read. Software then polls a read-result register until its busy flag drops. The result register holds the returned value and also echoes the address that was read, so software can confirm which register the data came from. A status register reports whether the write queue is full or empty, and carries a sticky overflow flag.

The serial engine is a state machine with three states. `ENG_IDLE` waits for work. If the write queue is not empty, it takes the **pop** transition: it removes the oldest entry and enters `ENG_SHIFT` to send a write frame. If the queue is empty and a read is pending, it takes the **read-start** transition into `ENG_SHIFT`. `ENG_SHIFT` clocks out all 29 bits of the frame and then takes the **frame-end** transition to `ENG_GAP`. `ENG_GAP` lasts one cycle, with chip select low. During that cycle the result of a read is handed to the register side. The state machine then takes the **return** transition back to `ENG_IDLE`. Because `ENG_IDLE` always serves queued writes before a pending read, a read never overtakes a write that was issued before it.

Top module: `pmic_bridge`

## Requirements
- R1: A bus write whose address bits [15:12] equal 4'h8 queues one entry, made of address bits [11:0] and write-data bits [15:0]. A bus write to any other address outside the registers below queues nothing.
- R2: Reading offset 0x30 returns the status register: bit 11 is 1 when the queue holds 8 entries, bit 10 is 1 when it holds none, bit 0 is the overflow flag, and all other bits are 0.
- R3: A window write that arrives while the queue is full is discarded and never reaches the device. It sets the overflow flag, and only reset clears that flag.
- R4: A bus write to offset 0x28 starts a read of the device address in write-data bits [11:0]. Bit 31 of offset 0x2C (busy) reads 1 from the next cycle until the result is stored. A write to offset 0x28 while busy is 1 is ignored.
- R5: Offset 0x2C returns the last read value in bits [15:0] and the 12-bit address of that read in bits [27:16]. Bits [30:28] are 0.
- R6: A read frame is sent only when the write queue is empty and no write frame is in progress. A read therefore returns data that includes every write queued before it.
- R7: A frame is 29 bits sent MSB first while chip select is high: an operation bit (1 = read, 0 = write), then 12 address bits, then 16 data bits. For each bit, the serial clock is low for SCLK_HALF cycles and then high for SCLK_HALF cycles. The device samples on the rising edge. On a read, the bridge samples the data bits on the serial input.
- R8: After reset, the queue is empty, the status register reads 0x400, and offset 0x2C reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Byte address of the bus access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| ser_sclk | output | 1 | Serial clock |
| ser_cs | output | 1 | Chip select, high for the whole frame |
| ser_mosi | output | 1 | Serial data to the device |
| ser_miso | input | 1 | Serial data from the device |

## Verification
The assertions assume that each bus write is held for exactly one clock and that reset is asserted before the first edge. They also assume that the serial input matters only while a read frame is in its data phase. The bench keeps within these limits: it changes inputs only a few nanoseconds after a falling clock edge, always drops the write strobe after one cycle unless it is deliberately sending a back-to-back burst, and uses a device model that drives the serial input only on falling serial-clock edges. The behavioural reference model counts queue entries from the bus writes and from the frame starts it sees on the serial pins. Every clock, it predicts the full, empty, overflow and busy flags.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_GAP   = 2'd2
    } eng_state_t;

    localparam int OFS_RD_CMD = 'h28;
    localparam int OFS_RD_RES = 'h2C;
    localparam int OFS_STATUS = 'h30;
    localparam int WIN_BASE   = 'h8000;

    localparam int ST_FULL_BIT  = 11;
    localparam int ST_EMPTY_BIT = 10;
    localparam int ST_OVF_BIT   = 0;
    localparam int RES_BUSY_BIT = 31;
    localparam int RES_ADDR_LSB = 16;

endpackage

// File: rtl/pb_wqueue.sv
module pb_wqueue #(
    parameter int AW    = 12,
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          full,
    output logic          empty,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [AW-1:0]    addr_mem [DEPTH];
    logic [DW-1:0]    data_mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign level   = cnt_q;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head_addr = addr_mem[rd_ptr];
    assign head_data = data_mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            addr_mem[wr_ptr] <= push_addr;
            data_mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R2: full and empty never together, level never beyond depth
    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty) && (cnt_q <= CNT_W'(DEPTH)));

    // R3: a push into a full queue without a pop leaves it full and unchanged
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(wr_ptr)));

endmodule

// File: rtl/pb_serial_eng.sv
module pb_serial_eng
    import pmic_bridge_pkg::*;
#(
    parameter int AW   = 12,
    parameter int DW   = 16,
    parameter int HALF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wq_empty,
    input  logic [AW-1:0] wq_addr,
    input  logic [DW-1:0] wq_data,
    output logic          wq_pop,
    input  logic          rd_pend,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_start,
    output logic          rd_done,
    output logic [DW-1:0] rd_val,
    output logic          ser_sclk,
    output logic          ser_cs,
    output logic          ser_mosi,
    input  logic          ser_miso
);
    localparam int FRAME_W = 1 + AW + DW;
    localparam int PH_W    = (2*HALF > 2) ? $clog2(2*HALF) : 1;
    localparam int BIT_W   = $clog2(FRAME_W);

    eng_state_t         state_q, state_d;
    logic [FRAME_W-1:0] out_q;
    logic [DW-1:0]      in_q;
    logic [PH_W-1:0]    phase_q;
    logic [BIT_W-1:0]   bit_q;
    logic               rd_q;
    logic               bit_end, last_bit;

    assign bit_end  = (phase_q == PH_W'(2*HALF-1));
    assign last_bit = (bit_q == BIT_W'(FRAME_W-1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:  if (!wq_empty || rd_pend) state_d = ENG_SHIFT;
            ENG_SHIFT: if (bit_end && last_bit)  state_d = ENG_GAP;
            ENG_GAP:   state_d = ENG_IDLE;
            default:   state_d = ENG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        wq_pop   = (state_q == ENG_IDLE) && !wq_empty;
        rd_start = (state_q == ENG_IDLE) && wq_empty && rd_pend;
        rd_done  = (state_q == ENG_GAP) && rd_q;
        ser_cs   = (state_q == ENG_SHIFT);
        ser_sclk = (state_q == ENG_SHIFT) && (phase_q >= PH_W'(HALF));
        ser_mosi = (state_q == ENG_SHIFT) && out_q[FRAME_W-1];
        rd_val   = in_q;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            in_q    <= '0;
            phase_q <= '0;
            bit_q   <= '0;
            rd_q    <= 1'b0;
        end else if (wq_pop) begin
            out_q   <= {1'b0, wq_addr, wq_data};
            rd_q    <= 1'b0;
            phase_q <= '0;
            bit_q   <= '0;
        end else if (rd_start) begin
            out_q   <= {1'b1, rd_addr, {DW{1'b0}}};
            rd_q    <= 1'b1;
            phase_q <= '0;
            bit_q   <= '0;
        end else if (state_q == ENG_SHIFT) begin
            if (phase_q == PH_W'(HALF)) in_q <= {in_q[DW-2:0], ser_miso};
            if (bit_end) begin
                phase_q <= '0;
                bit_q   <= bit_q + 1'b1;
                out_q   <= {out_q[FRAME_W-2:0], 1'b0};
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // R7: the serial clock only runs inside a frame
    p_sclk_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_cs |-> !ser_sclk);

    // R7: data out is stable while the serial clock is high
    p_mosi_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_sclk && $past(ser_sclk)) |-> $stable(ser_mosi));

endmodule

// File: rtl/pmic_bridge.sv
module pmic_bridge
    import pmic_bridge_pkg::*;
#(
    parameter int BUS_AW    = 16,
    parameter int REG_AW    = 12,
    parameter int REG_DW    = 16,
    parameter int WQ_DEPTH  = 8,
    parameter int SCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ser_sclk,
    output logic              ser_cs,
    output logic              ser_mosi,
    input  logic              ser_miso
);
    localparam int WIN_W   = BUS_AW - REG_AW;
    localparam int WIN_IDX = WIN_BASE >> REG_AW;
    localparam int LVL_W   = $clog2(WQ_DEPTH+1);

    logic              win_we, cmd_we;
    logic              wq_full, wq_empty, wq_pop;
    logic [LVL_W-1:0]  wq_level;
    logic [REG_AW-1:0] wq_addr;
    logic [REG_DW-1:0] wq_data;
    logic              rd_start, rd_done;
    logic [REG_DW-1:0] rd_val;

    logic              busy_q, pend_q, ovf_q;
    logic [REG_AW-1:0] cmd_addr_q, res_addr_q;
    logic [REG_DW-1:0] res_val_q;

    assign win_we = bus_we && (bus_addr[BUS_AW-1:REG_AW] == WIN_W'(WIN_IDX));
    assign cmd_we = bus_we && (bus_addr == BUS_AW'(OFS_RD_CMD));

    pb_wqueue #(.AW(REG_AW), .DW(REG_DW), .DEPTH(WQ_DEPTH)) u_wq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (win_we),
        .push_addr (bus_addr[REG_AW-1:0]),
        .push_data (bus_wdata[REG_DW-1:0]),
        .pop       (wq_pop),
        .head_addr (wq_addr),
        .head_data (wq_data),
        .full      (wq_full),
        .empty     (wq_empty),
        .level     (wq_level)
    );

    pb_serial_eng #(.AW(REG_AW), .DW(REG_DW), .HALF(SCLK_HALF)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .wq_empty (wq_empty),
        .wq_addr  (wq_addr),
        .wq_data  (wq_data),
        .wq_pop   (wq_pop),
        .rd_pend  (pend_q),
        .rd_addr  (cmd_addr_q),
        .rd_start (rd_start),
        .rd_done  (rd_done),
        .rd_val   (rd_val),
        .ser_sclk (ser_sclk),
        .ser_cs   (ser_cs),
        .ser_mosi (ser_mosi),
        .ser_miso (ser_miso)
    );

    // read command and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            pend_q     <= 1'b0;
            cmd_addr_q <= '0;
            res_addr_q <= '0;
            res_val_q  <= '0;
        end else if (cmd_we && !busy_q) begin
            busy_q     <= 1'b1;
            pend_q     <= 1'b1;
            cmd_addr_q <= bus_wdata[REG_AW-1:0];
        end else begin
            if (rd_start) pend_q <= 1'b0;
            if (rd_done) begin
                busy_q     <= 1'b0;
                res_addr_q <= cmd_addr_q;
                res_val_q  <= rd_val;
            end
        end
    end

    // sticky overflow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ovf_q <= 1'b0;
        else if (win_we && wq_full)  ovf_q <= 1'b1;
    end

    // register read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == BUS_AW'(OFS_RD_RES)) begin
            bus_rdata[RES_BUSY_BIT]                = busy_q;
            bus_rdata[RES_ADDR_LSB +: REG_AW]      = res_addr_q;
            bus_rdata[REG_DW-1:0]                  = res_val_q;
        end else if (bus_addr == BUS_AW'(OFS_STATUS)) begin
            bus_rdata[ST_FULL_BIT]  = wq_full;
            bus_rdata[ST_EMPTY_BIT] = wq_empty;
            bus_rdata[ST_OVF_BIT]   = ovf_q;
        end
    end

    // R4: an accepted read command raises busy on the next cycle
    p_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy_q) |=> busy_q);

    // R4: busy stays up until the engine hands back a result
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !rd_done) |=> busy_q);

    // R3: overflow is sticky
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R6: a read frame starts only with nothing left in the queue
    p_read_after_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> (wq_level == '0));

endmodule

// File: tb/test_pmic_bridge.sv
module test_pmic_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0030;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_sclk, ser_cs, ser_mosi;
    logic        ser_miso = 1'b0;

    always #10 clk = ~clk;

    pmic_bridge i_pmic_bridge (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_sclk(ser_sclk),
        .ser_cs(ser_cs), .ser_mosi(ser_mosi), .ser_miso(ser_miso)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    function automatic logic [15:0] init_val(input int a);
        return 16'((a * 16'h0397) ^ 16'h5A5A);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // ---------------- device model on the serial link ----------------
    logic [15:0] sl_mem [4096];
    logic [15:0] exp_mem [4096];
    logic [28:0] sl_frame = '0, last_frame = '0;
    int          sl_cnt = 0, last_cnt = 0;
    logic [15:0] sl_out = '0;

    always @(posedge ser_cs) sl_cnt = 0;
    always @(posedge ser_sclk) begin
        sl_frame = {sl_frame[27:0], ser_mosi};
        sl_cnt++;
        if (sl_cnt == 13 && sl_frame[12]) sl_out = sl_mem[sl_frame[11:0]];
    end
    always @(negedge ser_sclk) begin
        if (ser_cs && sl_cnt >= 13 && sl_cnt < 29 && sl_frame[sl_cnt-1]) begin
            ser_miso = sl_out[15];
            sl_out   = {sl_out[14:0], 1'b0};
        end
    end
    always @(negedge ser_cs) begin
        last_frame = sl_frame;
        last_cnt   = sl_cnt;
        if (sl_cnt == 29 && !sl_frame[28]) sl_mem[sl_frame[27:16]] = sl_frame[15:0];
    end

    // ---------------- cycle reference model ----------------
    logic [27:0] mq[$];
    logic [27:0] exp_frame = '0;
    bit m_busy = 0, m_ovf = 0, clr_pend = 0, cs_prev = 0, fr_rd = 0, mdl_on = 0;

    always @(negedge clk) begin
        if (mdl_on) begin
            bit b_before;
            b_before = m_busy;
            if (clr_pend) begin m_busy = 0; clr_pend = 0; end
            if (bus_we && bus_addr == 16'h0028 && !b_before) m_busy = 1;
            if (bus_we && bus_addr[15:12] == 4'h8) begin
                if (mq.size() == 8) m_ovf = 1;
                else begin
                    mq.push_back({bus_addr[11:0], bus_wdata[15:0]});
                    exp_mem[bus_addr[11:0]] = bus_wdata[15:0];
                end
            end
            if (ser_cs && !cs_prev) begin
                fr_rd = ser_mosi;
                if (!ser_mosi) exp_frame = mq.pop_front();
            end
            if (!ser_cs && cs_prev) begin
                if (fr_rd) clr_pend = 1;
                else chk(last_cnt == 29 && last_frame == {1'b0, exp_frame},
                         "R7 write frame bits", {3'b0, last_frame}, {4'b0, exp_frame});
            end
            cs_prev = ser_cs;
            if (bus_addr == 16'h0030)
                chk(bus_rdata == ({20'b0, (mq.size() == 8), (mq.size() == 0), 9'b0, m_ovf}),
                    "R2 status per-cycle", bus_rdata,
                    {20'b0, (mq.size() == 8), (mq.size() == 0), 9'b0, m_ovf});
            if (bus_addr == 16'h002C)
                chk(bus_rdata[31] == m_busy, "R4 busy per-cycle", {31'b0, bus_rdata[31]}, {31'b0, m_busy});
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #2;
        bus_we = 1'b0; bus_addr = 16'h0030;
    endtask

    task automatic wait_result(output logic [31:0] r);
        bus_we = 1'b0; bus_addr = 16'h002C;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); #1;
            if (!bus_rdata[31]) break;
        end
        r = bus_rdata;
        @(negedge clk); #2;
        bus_addr = 16'h0030;
    endtask

    task automatic do_read(input logic [31:0] cmd, output logic [31:0] r);
        bus_wr(16'h0028, cmd);
        wait_result(r);
    endtask

    task automatic read_chk(input logic [11:0] a, input string tag);
        logic [31:0] r;
        do_read({20'b0, a}, r);
        chk(r[15:0] == exp_mem[a], tag, {16'b0, r[15:0]}, {16'b0, exp_mem[a]});
        chk(r[30:16] == {3'b0, a}, "R5 echo", {17'b0, r[30:16]}, {20'b0, a});
    endtask

    task automatic wait_empty;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); #1;
            if (bus_rdata[10]) break;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] r;
        for (int a = 0; a < 4096; a++) begin
            sl_mem[a]  = init_val(a);
            exp_mem[a] = init_val(a);
        end
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(bus_rdata == 32'h0000_0400, "R8 reset status", bus_rdata, 32'h400);
        bus_addr = 16'h002C; #1;
        chk(bus_rdata == 32'h0, "R8 reset result", bus_rdata, 32'h0);
        @(negedge clk); #2 bus_addr = 16'h0030;
        mdl_on = 1;

        // R1 basic write and read back
        bus_wr(16'h8010, 32'hFFFF_1234);
        read_chk(12'h010, "R1 window write reaches device");
        read_chk(12'h3A5, "R4 read of untouched register");

        // R6 ordering: queued writes then read of the same register
        @(negedge clk); #2;
        bus_we = 1; bus_addr = 16'h8020; bus_wdata = 32'h1111;
        @(negedge clk); #2 bus_wdata = 32'h2222;
        @(negedge clk); #2 bus_wdata = 32'hBEEF;
        @(negedge clk); #2 bus_addr = 16'h0028; bus_wdata = 32'h020;
        @(negedge clk); #2 bus_we = 0;
        wait_result(r);
        chk(r[15:0] == 16'hBEEF, "R6 read after queued writes", {16'b0, r[15:0]}, 32'hBEEF);

        // R3 burst of 12 back-to-back writes into a slow link
        wait_empty();
        @(negedge clk); #2 bus_we = 1;
        for (int i = 0; i < 12; i++) begin
            bus_addr = 16'h8100 + 16'(i); bus_wdata = 32'hA000 + i;
            @(negedge clk); #2;
        end
        bus_we = 0; bus_addr = 16'h0030; #1;
        chk(bus_rdata[11] == 1'b1, "R2 full after burst", {31'b0, bus_rdata[11]}, 32'h1);
        chk(bus_rdata[0] == 1'b1, "R3 overflow set", {31'b0, bus_rdata[0]}, 32'h1);
        for (int i = 0; i < 12; i++) read_chk(12'h100 + 12'(i), "R3 burst read back");
        chk(exp_mem[12'h10B] == init_val('h10B), "R3 last burst write dropped",
            {16'b0, exp_mem[12'h10B]}, {16'b0, init_val('h10B)});
        bus_addr = 16'h0030; #1;
        chk(bus_rdata[0] == 1'b1 && bus_rdata[10] == 1'b1, "R3 overflow sticky after drain",
            bus_rdata, 32'h401);

        // R1 writes outside the window are ignored
        bus_wr(16'h9004, 32'h5555);
        #1 chk(bus_rdata[10] == 1'b1, "R1 outside write not queued", bus_rdata, 32'h401);
        bus_wr(16'h7FFC, 32'h6666);
        #1 chk(bus_rdata[10] == 1'b1, "R1 outside write not queued 2", bus_rdata, 32'h401);
        read_chk(12'h004, "R1 outside write no effect");
        read_chk(12'hFFC, "R1 outside write no effect 2");

        // R4 second command while busy is ignored
        @(negedge clk); #2;
        bus_we = 1; bus_addr = 16'h0028; bus_wdata = 32'h030;
        @(negedge clk); #2 bus_wdata = 32'h040;
        @(negedge clk); #2 bus_we = 0;
        wait_result(r);
        chk(r[27:16] == 12'h030, "R4 command while busy ignored", {20'b0, r[27:16]}, 32'h030);
        chk(r[15:0] == exp_mem[12'h030], "R4 data of first command", {16'b0, r[15:0]}, {16'b0, exp_mem[12'h030]});

        // R5 upper command bits do not reach the echo
        do_read(32'h0000_F123, r);
        chk(r[30:16] == 15'h0123, "R5 echo masked to 12 bits", {17'b0, r[30:16]}, 32'h123);
        chk(r[15:0] == exp_mem[12'h123], "R5 data field", {16'b0, r[15:0]}, {16'b0, exp_mem[12'h123]});

        repeat (4) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule